// File: doc/BRIEF.md
# LIN Header Break and Baud-Rate Detector

This block sits on the receive path of a LIN slave node and recognises the start of each frame header. It times every dominant (low) stretch on the synchronised receive line. A low stretch of at least thirteen nominal bit times counts as a frame break. It is reported when the line goes recessive again, and it is recognised in every state of the detector, so it can cut into a measurement already in progress.

After a break, the block ignores the recessive delimiter and waits for the first falling edge of the sync byte. It then counts clock cycles up to the fifth falling edge. That span covers eight bit times, so shifting it right by three gives the master's bit period in clock cycles. A companion UART loads this value as its divisor to receive the protected identifier and the one to eight data bytes that follow.

A line held low for far longer than any plausible break raises a bus-fault level. The fault threshold is a programmable number of nominal bit times, normally 64. The nominal bit period is given in clock cycles. Reset is asynchronous and active-low, and the surrounding reset logic is expected to release it in step with the clock.

Top module: `lin_hdr_detect`

## Requirements
- R1: While reset is asserted, and after it is released, `brk_det`, `sync_done`, `sync_tmo` and `bus_fault` are 0 and `bit_period` is 0.
- R2: A low run of L cycles with 13·N ≤ L < F·N gives a one-cycle `brk_det` pulse. N is `nom_bit_cycles` and F is `fault_mult`. The pulse is visible in the cycle after the clock edge that first samples the line high, including the boundary lengths L = 13·N and L = F·N − 1.
- R3: A low run shorter than 13·N cycles (for example 13·N − 1) produces no `brk_det` and does not start a sync measurement.
- R4: `bus_fault` is 1 after every clock edge at which the low run has reached F·N cycles. It returns to 0 after the first edge that samples the line high. A low run that reached F·N cycles produces no `brk_det`.
- R5: A break is recognised in every state. A break that arrives during a sync measurement abandons it and restarts the wait for the first sync falling edge.
- R6: After a break, the rising delimiter edge is ignored. The span is counted from the first falling edge of the sync byte.
- R7: On the clock edge that samples the fifth falling edge, `sync_done` pulses for one cycle. `bit_period` then takes the value (t5 − t1) >> 3, where t1 and t5 are the edge cycles of the first and fifth falling edges. `bit_period` holds that value until the next `sync_done`.
- R8: If the span reaches 2^SPAN_W − 1 cycles before the fifth falling edge, `sync_tmo` pulses for one cycle and the detector goes back to waiting for a break. Later edges then give no `sync_done` until a new break.
- R9: If the fifth falling edge arrives on the same edge that the span reaches 2^SPAN_W − 1, the measurement completes: `sync_done` pulses, `bit_period` becomes all ones, and `sync_tmo` stays 0.
- R10: Falling edges that follow no break, such as a sync-shaped byte on an idle bus or after a bus fault, never produce `sync_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Synchronised receive line, 1 = recessive |
| nom_bit_cycles | input | NOM_W (16) | Nominal bit period in clock cycles, at least 1 |
| fault_mult | input | FAULT_W (8) | Bus-fault threshold in nominal bit times, above 13 (normally 64) |
| brk_det | output | 1 | One-cycle pulse: break recognised |
| sync_done | output | 1 | One-cycle pulse: sync span measured, `bit_period` updated |
| sync_tmo | output | 1 | One-cycle pulse: sync span counter saturated |
| bus_fault | output | 1 | Level: line held low for at least the fault threshold |
| bit_period | output | SPAN_W−3 (16) | Measured bit period in clock cycles |

## Verification
Completion and timeout of the sync measurement can fall on the same clock edge. This happens when the fifth falling edge lands exactly as the span counter reaches its limit. The bench runs the counter narrowed to 13 bits and places the five falling edges by cycle count so that the span is exactly 8191. It expects one `sync_done`, no `sync_tmo` and a period of 1023. A second case pairs a break with a measurement that is half done: the low run that completes the break starts with what the measurement sees as its third falling edge. The break must win, and only the next sync byte may complete.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

  // Falling edges of the sync byte that bound the measured span.
  localparam int SYNC_FALLS   = 5;
  // The span covers two bit times per falling-edge gap.
  localparam int PERIOD_SHIFT = $clog2(2 * (SYNC_FALLS - 1));
  localparam int FALL_CNT_W   = $clog2(SYNC_FALLS);

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,  // waiting for a break
    ST_WAIT_FALL = 2'd1,  // break seen, waiting for first sync falling edge
    ST_MEASURE   = 2'd2   // timing the sync byte
  } sync_state_e;

endpackage

// File: rtl/lin_edge_track.sv
module lin_edge_track (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic fall
);

  logic rxd_q;
  logic rxd_d;

  always_comb begin
    rxd_d = rxd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_q <= 1'b1;
    end else begin
      rxd_q <= rxd_d;
    end
  end

  assign fall = rxd_q & ~rxd;

endmodule

// File: rtl/lin_low_timer.sv
module lin_low_timer #(
  parameter int NOM_W      = 16,
  parameter int FAULT_W    = 8,
  parameter int BREAK_BITS = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rxd,
  input  logic [NOM_W-1:0]   nom_bit_cycles,
  input  logic [FAULT_W-1:0] fault_mult,
  output logic               brk_evt,
  output logic               fault_lvl
);

  localparam logic [FAULT_W-1:0] BITS_SAT = '1;
  localparam logic [FAULT_W-1:0] BRK_LIM  = FAULT_W'(BREAK_BITS);

  // Low time is kept as whole bit times plus a cycle count within the bit.
  logic [NOM_W-1:0]   sub_q, sub_d;
  logic [FAULT_W-1:0] bits_q, bits_d;
  logic               sub_wrap;
  logic               cnt_en;

  assign sub_wrap = (sub_q == (nom_bit_cycles - NOM_W'(1)));
  assign cnt_en   = ~rxd;

  always_comb begin
    sub_d  = sub_q;
    bits_d = bits_q;
    if (!cnt_en) begin
      sub_d  = '0;
      bits_d = '0;
    end else if (sub_wrap) begin
      sub_d = '0;
      if (bits_q != BITS_SAT) begin
        bits_d = bits_q + FAULT_W'(1);
      end
    end else begin
      sub_d = sub_q + NOM_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= '0;
      bits_q <= '0;
    end else begin
      sub_q  <= sub_d;
      bits_q <= bits_d;
    end
  end

  // A break ends on the first high sample after a long enough low run that
  // did not reach the fault threshold.
  assign brk_evt   = rxd & (bits_q >= BRK_LIM) & (bits_q < fault_mult);
  assign fault_lvl = (bits_q >= fault_mult);

endmodule

// File: rtl/lin_sync_meas.sv
module lin_sync_meas
  import lin_hdr_pkg::*;
#(
  parameter int SPAN_W = 19,
  parameter int PER_W  = SPAN_W - PERIOD_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_i,
  input  logic             brk_i,
  output logic             done_o,
  output logic             tmo_o,
  output logic [PER_W-1:0] period_o
);

  localparam logic [SPAN_W-1:0]     SPAN_MAX  = '1;
  localparam logic [FALL_CNT_W-1:0] FALL_LAST = FALL_CNT_W'(SYNC_FALLS - 1);

  sync_state_e            st_q, st_d;
  logic [SPAN_W-1:0]      span_q, span_d, span_inc;
  logic [FALL_CNT_W-1:0]  fe_q, fe_d;
  logic [PER_W-1:0]       per_q, per_d;
  logic                   done_q, done_d;
  logic                   tmo_q, tmo_d;

  assign span_inc = span_q + SPAN_W'(1);

  always_comb begin
    st_d   = st_q;
    span_d = span_q;
    fe_d   = fe_q;
    per_d  = per_q;
    done_d = 1'b0;
    tmo_d  = 1'b0;
    if (brk_i) begin
      // A break overrides any state: restart the header.
      st_d   = ST_WAIT_FALL;
      span_d = '0;
      fe_d   = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_d = ST_IDLE;
        end
        ST_WAIT_FALL: begin
          if (fall_i) begin
            st_d   = ST_MEASURE;
            span_d = '0;
            fe_d   = FALL_CNT_W'(1);
          end
        end
        ST_MEASURE: begin
          if (fall_i && (fe_q == FALL_LAST)) begin
            // Completion takes priority over saturation in the same cycle.
            done_d = 1'b1;
            per_d  = span_inc[SPAN_W-1:PERIOD_SHIFT];
            st_d   = ST_IDLE;
          end else if (span_inc == SPAN_MAX) begin
            tmo_d = 1'b1;
            st_d  = ST_IDLE;
          end else begin
            span_d = span_inc;
            if (fall_i) begin
              fe_d = fe_q + FALL_CNT_W'(1);
            end
          end
        end
        default: begin
          st_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      span_q <= '0;
      fe_q   <= '0;
      per_q  <= '0;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      span_q <= span_d;
      fe_q   <= fe_d;
      per_q  <= per_d;
      done_q <= done_d;
      tmo_q  <= tmo_d;
    end
  end

  assign done_o   = done_q;
  assign tmo_o    = tmo_q;
  assign period_o = per_q;

endmodule

// File: rtl/lin_hdr_detect.sv
module lin_hdr_detect
  import lin_hdr_pkg::*;
#(
  parameter int NOM_W      = 16,
  parameter int FAULT_W    = 8,
  parameter int BREAK_BITS = 13,
  parameter int SPAN_W     = 19
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rxd,
  input  logic [NOM_W-1:0]               nom_bit_cycles,
  input  logic [FAULT_W-1:0]             fault_mult,
  output logic                           brk_det,
  output logic                           sync_done,
  output logic                           sync_tmo,
  output logic                           bus_fault,
  output logic [SPAN_W-PERIOD_SHIFT-1:0] bit_period
);

  localparam int PER_W = SPAN_W - PERIOD_SHIFT;

  logic fall;
  logic brk_evt;
  logic fault_lvl;
  logic brk_q, brk_d;

  lin_edge_track u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .rxd  (rxd),
    .fall (fall)
  );

  lin_low_timer #(
    .NOM_W     (NOM_W),
    .FAULT_W   (FAULT_W),
    .BREAK_BITS(BREAK_BITS)
  ) u_low (
    .clk           (clk),
    .rst_n         (rst_n),
    .rxd           (rxd),
    .nom_bit_cycles(nom_bit_cycles),
    .fault_mult    (fault_mult),
    .brk_evt       (brk_evt),
    .fault_lvl     (fault_lvl)
  );

  lin_sync_meas #(
    .SPAN_W(SPAN_W),
    .PER_W (PER_W)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .fall_i  (fall),
    .brk_i   (brk_evt),
    .done_o  (sync_done),
    .tmo_o   (sync_tmo),
    .period_o(bit_period)
  );

  always_comb begin
    brk_d = brk_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q <= 1'b0;
    end else begin
      brk_q <= brk_d;
    end
  end

  assign brk_det   = brk_q;
  assign bus_fault = fault_lvl;

endmodule

// File: rtl/lin_hdr_checker.sv
module lin_hdr_checker #(
  parameter int PER_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rxd,
  input logic             brk_det,
  input logic             sync_done,
  input logic             sync_tmo,
  input logic             bus_fault,
  input logic [PER_W-1:0] bit_period
);

  // R9: completion and timeout never reported together
  assert_done_tmo_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_done && sync_tmo));

  // R2: break report is a single-cycle pulse
  assert_brk_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det |=> !brk_det);

  // R2: break is only reported after the line was sampled high
  assert_brk_after_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det |-> $past(rxd));

  // R4: a high sample clears the fault level
  assert_fault_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rxd |=> !bus_fault);

  // R4: a faulted low run never turns into a break
  assert_fault_no_brk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fault |=> !brk_det);

  // R7: the measured period only moves together with a completion pulse
  assert_period_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_done |-> $stable(bit_period));

endmodule

bind lin_hdr_detect lin_hdr_checker #(.PER_W(PER_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rxd       (rxd),
  .brk_det   (brk_det),
  .sync_done (sync_done),
  .sync_tmo  (sync_tmo),
  .bus_fault (bus_fault),
  .bit_period(bit_period)
);

// File: tb/test_lin_hdr_detect.sv
module test_lin_hdr_detect;

  localparam int CLK_PERIOD = 10;
  localparam int SPAN_W     = 13;
  localparam int PER_W      = SPAN_W - 3;
  localparam int NOM        = 40;
  localparam int FMULT      = 20;
  localparam int BRK_MIN    = 13 * NOM;
  localparam int FAULT_LEN  = FMULT * NOM;
  localparam int SPAN_LIM   = (1 << SPAN_W) - 1;
  localparam int WATCHDOG   = 150000;

  logic             clk;
  logic             rst_n;
  logic             rxd;
  logic [15:0]      nom_bit_cycles;
  logic [7:0]       fault_mult;
  logic             brk_det;
  logic             sync_done;
  logic             sync_tmo;
  logic             bus_fault;
  logic [PER_W-1:0] bit_period;

  lin_hdr_detect #(.SPAN_W(SPAN_W)) i_lin_hdr_detect (
    .clk           (clk),
    .rst_n         (rst_n),
    .rxd           (rxd),
    .nom_bit_cycles(nom_bit_cycles),
    .fault_mult    (fault_mult),
    .brk_det       (brk_det),
    .sync_done     (sync_done),
    .sync_tmo      (sync_tmo),
    .bus_fault     (bus_fault),
    .bit_period    (bit_period)
  );

  int vectors = 0;
  int fails   = 0;
  bit ended   = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // Behavioural reference: timestamps and a run-length integer.
  int m_low, m_st, m_t0, m_fe, cyc, m_span, e_per;
  bit m_rxq, e_brk, e_done, e_tmo, e_fault, m_fall, m_brk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_low = 0; m_st = 0; m_t0 = 0; m_fe = 0; cyc = 0; e_per = 0;
      m_rxq = 1; e_brk = 0; e_done = 0; e_tmo = 0; e_fault = 0;
    end else begin
      m_fall = (rxd == 1'b0) && m_rxq;
      m_brk  = (rxd == 1'b1) && (m_low >= BRK_MIN) && (m_low < FAULT_LEN);
      e_brk = m_brk; e_done = 0; e_tmo = 0;
      if (m_brk) begin
        m_st = 1;
      end else if (m_st == 1) begin
        if (m_fall) begin m_st = 2; m_t0 = cyc; m_fe = 1; end
      end else if (m_st == 2) begin
        m_span = cyc - m_t0;
        if (m_fall && m_fe == 4) begin
          e_done = 1; e_per = m_span / 8; m_st = 0;
        end else if (m_span >= SPAN_LIM) begin
          e_tmo = 1; m_st = 0;
        end else if (m_fall) begin
          m_fe++;
        end
      end
      m_low   = rxd ? 0 : m_low + 1;
      m_rxq   = rxd;
      e_fault = (m_low >= FAULT_LEN);
      cyc++;
    end
  end

  // Per-clock comparison, away from the active edge.
  bit cmp_en = 0;
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      check("R2 brk_det", int'(brk_det), int'(e_brk));
      check("R7 sync_done", int'(sync_done), int'(e_done));
      check("R8 sync_tmo", int'(sync_tmo), int'(e_tmo));
      check("R4 bus_fault", int'(bus_fault), int'(e_fault));
      check("R7 bit_period", int'(bit_period), e_per);
    end
  end

  int n_brk, n_done, n_tmo, n_fault;
  always @(negedge clk) begin
    if (rst_n) begin
      if (brk_det)   n_brk++;
      if (sync_done) n_done++;
      if (sync_tmo)  n_tmo++;
      if (bus_fault) n_fault++;
    end
  end

  task automatic clear_counts();
    @(negedge clk);
    n_brk = 0; n_done = 0; n_tmo = 0; n_fault = 0;
  endtask

  task automatic drive(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxd = v;
    end
  endtask

  task automatic sync_byte(input int b);
    drive(1'b0, b);
    for (int k = 0; k < 8; k++) drive((k % 2 == 0) ? 1'b1 : 1'b0, b);
    drive(1'b1, b);
    drive(1'b1, 4);
  endtask

  task automatic send_break(input int len);
    drive(1'b0, len);
    drive(1'b1, NOM);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
    finish_run();
  end

  initial begin
    rxd = 1'b1;
    rst_n = 1'b0;
    nom_bit_cycles = 16'(NOM);
    fault_mult = 8'(FMULT);
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check("R1 brk_det", int'(brk_det), 0);
    check("R1 sync_done", int'(sync_done), 0);
    check("R1 sync_tmo", int'(sync_tmo), 0);
    check("R1 bus_fault", int'(bus_fault), 0);
    check("R1 bit_period", int'(bit_period), 0);
    @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1;
    drive(1'b1, 5);
    check("R1 bit_period after release", int'(bit_period), 0);

    // R10: sync-shaped byte without a break
    clear_counts();
    sync_byte(NOM);
    check("R10 no done on idle bus", n_done, 0);

    // R3: low run one cycle short of a break
    clear_counts();
    send_break(BRK_MIN - 1);
    sync_byte(NOM);
    check("R3 no brk when short", n_brk, 0);
    check("R3 no done when short", n_done, 0);

    // R2 R6 R7: minimum break, nominal sync
    clear_counts();
    send_break(BRK_MIN);
    sync_byte(NOM);
    check("R2 brk at minimum", n_brk, 1);
    check("R7 one done", n_done, 1);
    check("R7 period nominal", int'(bit_period), NOM);

    // R7: other rates, held between measurements
    clear_counts();
    send_break(BRK_MIN + 7);
    sync_byte(37);
    check("R7 period 37", int'(bit_period), 37);
    drive(1'b1, 30);
    check("R7 period held", int'(bit_period), 37);
    send_break(FAULT_LEN - 1);
    sync_byte(45);
    check("R2 brk just under fault", n_brk, 2);
    check("R4 no fault under threshold", n_fault, 0);
    check("R7 period 45", int'(bit_period), 45);

    // R5: break cutting into a measurement
    clear_counts();
    send_break(14 * NOM);
    drive(1'b0, NOM); drive(1'b1, NOM);
    drive(1'b0, NOM); drive(1'b1, NOM);
    drive(1'b0, 15 * NOM);
    drive(1'b1, NOM);
    check("R5 no done from cut measurement", n_done, 0);
    check("R5 two breaks", n_brk, 2);
    sync_byte(50);
    check("R5 done after restart", n_done, 1);
    check("R5 period after restart", int'(bit_period), 50);

    // R4: bus held low past the fault threshold
    clear_counts();
    drive(1'b0, FAULT_LEN + 10);
    @(negedge clk);
    check("R4 fault raised", int'(bus_fault), 1);
    rxd = 1'b1;
    @(negedge clk);
    check("R4 fault cleared", int'(bus_fault), 0);
    check("R4 no brk from fault", n_brk, 0);
    sync_byte(NOM);
    check("R10 no done after fault", n_done, 0);
    check("R4 period kept", int'(bit_period), 50);

    // R8: span saturation before the fifth edge
    clear_counts();
    send_break(BRK_MIN);
    drive(1'b0, NOM);
    drive(1'b1, SPAN_LIM + 20);
    check("R8 one timeout", n_tmo, 1);
    sync_byte(NOM);
    check("R8 no done after timeout", n_done, 0);
    check("R8 period kept", int'(bit_period), 50);

    // R9: fifth edge on the saturating cycle
    clear_counts();
    send_break(BRK_MIN);
    drive(1'b0, 10); drive(1'b1, 1990);
    drive(1'b0, 10); drive(1'b1, 1990);
    drive(1'b0, 10); drive(1'b1, 1990);
    drive(1'b0, 10); drive(1'b1, SPAN_LIM - 6000 - 10);
    drive(1'b0, 10); drive(1'b1, 20);
    check("R9 done on coincidence", n_done, 1);
    check("R9 no timeout on coincidence", n_tmo, 0);
    check("R9 saturated period", int'(bit_period), SPAN_LIM >> 3);

    drive(1'b1, 5);
    finish_run();
  end

endmodule